// File: doc/BRIEF.md
# Link Port Service-Request Interrupt Generator

This block watches the clock and acknowledge pins of a set of link ports and tells software, through one interrupt line, that a port it has not yet enabled is being driven by a partner. Activity on a port's incoming clock pin means a partner wants to send data to it, which is a receive request. Activity on its acknowledge pin means a partner is ready to accept data from it, which is a transmit request. Each port has one receive request bit and one transmit request bit in a status word.

Every request bit has its own mask bit. The masked bits are ORed into a registered interrupt output that feeds the chip's priority encoder. Software reads the status word to find which port raised the request and in which direction. A read through the main view clears the bits whose condition has gone. A read through the shadow view returns the same bits and changes nothing. The pins are asynchronous and are synchronized inside the block. Enabling a port forces both of its request bits to zero.

Top module: `link_srv_req`

## Requirements
- R1: After reset, every status bit and `irq_o` are 0.
- R2: Status bit 2p is the receive request of port p and is set by that port's clock pin. Bit 2p+1 is the transmit request of port p and is set by its acknowledge pin.
- R3: A request bit can set only while its port's enable is 0. One clock edge after the enable is sampled high, both of that port's bits are 0, and they stay 0 while the enable remains high.
- R4: A pin that rises between two clock edges shows in the status on the third rising edge after the change, which is 2 to 3 cycles later, and not on an earlier edge.
- R5: A set request bit stays set after its pin falls until a main-view read clears it or the port is enabled.
- R6: A main-view read (`rd_en_i`=1, `rd_view_i`=0) clears, on that edge, every bit whose synchronized condition is absent. A bit whose condition is still present stays set.
- R7: A shadow-view read (`rd_en_i`=1, `rd_view_i`=1) returns the same bits and clears none of them.
- R8: Bit 2p reaches the interrupt only when `rx_mask_i[p]`=1. Bit 2p+1 reaches it only when `tx_mask_i[p]`=1.
- R9: `irq_o` is the registered OR of all masked status bits. It rises one edge after the first masked bit sets and falls one edge after the last masked bit clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lnk_clk_i | input | N_PORTS | Asynchronous incoming link clock pins, one per port |
| lnk_ack_i | input | N_PORTS | Asynchronous acknowledge pins, one per port |
| port_en_i | input | N_PORTS | Port enable bits; 1 blocks and clears requests |
| rx_mask_i | input | N_PORTS | Receive request interrupt masks; 1 passes the request |
| tx_mask_i | input | N_PORTS | Transmit request interrupt masks; 1 passes the request |
| rd_en_i | input | 1 | Status read strobe |
| rd_view_i | input | 1 | Read view: 0 = main view (clears bits), 1 = shadow view |
| rd_data_o | output | 2*N_PORTS | Status word: bit 2p receive, bit 2p+1 transmit of port p |
| irq_o | output | 1 | Service-request interrupt |

## Verification
The bench times the pin-to-status path edge by edge. A design with one synchronizer stage too few or too many would show the bit on the wrong edge. It also reads while a pin is still high, where a design that clears without looking at the condition would drop a live request. A shadow read must leave the word untouched, which a clear wired to both views would break. The bench enables a port while its bit is set and its pin is held high, and changes masks on bits that are already set. A design that only blocks new sets on enable, or that takes masks from the wrong direction or port, fails there. A design without the interrupt register would fail the one-edge rise and fall timing.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic {
    RD_MAIN   = 1'b0,
    RD_SHADOW = 1'b1
  } rd_view_e;

  localparam int unsigned REQ_PER_PORT = 2;
  localparam int unsigned REQ_RX       = 0;
  localparam int unsigned REQ_TX       = 1;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsr_port_req.sv
module lsr_port_req
  import lsr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lnk_clk_i,
  input  logic                    lnk_ack_i,
  input  logic                    port_en_i,
  input  logic                    clr_i,
  output logic [REQ_PER_PORT-1:0] req_o
);
  logic                    clk_s, ack_s;
  logic [REQ_PER_PORT-1:0] cond, req_q;

  lsr_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lnk_clk_i), .q_o(clk_s)
  );
  lsr_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lnk_ack_i), .q_o(ack_s)
  );

  always_comb begin
    cond         = '0;
    cond[REQ_RX] = clk_s & ~port_en_i;
    cond[REQ_TX] = ack_s & ~port_en_i;
  end

  // sticky; a clearing read keeps bits whose condition is still live
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= '0;
    else if (port_en_i) req_q <= '0;
    else                req_q <= cond | (req_q & ~{REQ_PER_PORT{clr_i}});
  end

  assign req_o = req_q;
endmodule

// File: rtl/lsr_irq_merge.sv
module lsr_irq_merge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(req_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/link_srv_req.sv
module link_srv_req
  import lsr_pkg::*;
#(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STAT_W     = N_PORTS * REQ_PER_PORT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PORTS-1:0] lnk_clk_i,
  input  logic [N_PORTS-1:0] lnk_ack_i,
  input  logic [N_PORTS-1:0] port_en_i,
  input  logic [N_PORTS-1:0] rx_mask_i,
  input  logic [N_PORTS-1:0] tx_mask_i,
  input  logic              rd_en_i,
  input  logic              rd_view_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status, mask_vec;
  logic              clr_main;

  assign clr_main = rd_en_i && (rd_view_e'(rd_view_i) == RD_MAIN);

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      lsr_port_req #(.SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lnk_clk_i(lnk_clk_i[p]),
        .lnk_ack_i(lnk_ack_i[p]),
        .port_en_i(port_en_i[p]),
        .clr_i    (clr_main),
        .req_o    (status[REQ_PER_PORT*p +: REQ_PER_PORT])
      );
      assign mask_vec[REQ_PER_PORT*p + REQ_RX] = rx_mask_i[p];
      assign mask_vec[REQ_PER_PORT*p + REQ_TX] = tx_mask_i[p];
    end
  endgenerate

  lsr_irq_merge #(.WIDTH(STAT_W)) u_merge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (status),
    .mask_i(mask_vec),
    .irq_o (irq_o)
  );

  assign rd_data_o = status;
endmodule

// File: rtl/link_srv_req_chk.sv
module link_srv_req_chk #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned STAT_W = 2 * N_PORTS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PORTS-1:0] port_en_i,
  input logic [N_PORTS-1:0] rx_mask_i,
  input logic [N_PORTS-1:0] tx_mask_i,
  input logic              rd_en_i,
  input logic              rd_view_i,
  input logic [STAT_W-1:0] rd_data_o,
  input logic              irq_o
);
  logic [STAT_W-1:0] en_vec, msk_vec;
  logic              main_rd;

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      en_vec[2*p]    = port_en_i[p];
      en_vec[2*p+1]  = port_en_i[p];
      msk_vec[2*p]   = rx_mask_i[p];
      msk_vec[2*p+1] = tx_mask_i[p];
    end
  end
  assign main_rd = rd_en_i && !rd_view_i;

  p_en_forces_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & $past(en_vec)) == '0);

  // bits only fall through a main read or an enable (R5, R7)
  p_hold_until_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_rd |=> (($past(rd_data_o) & ~rd_data_o & ~$past(en_vec)) == '0));

  p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rd_data_o & msk_vec)) |=> irq_o);

  p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(rd_data_o & msk_vec)) |=> !irq_o);
endmodule

bind link_srv_req link_srv_req_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .port_en_i(port_en_i),
  .rx_mask_i(rx_mask_i),
  .tx_mask_i(tx_mask_i),
  .rd_en_i  (rd_en_i),
  .rd_view_i(rd_view_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o)
);

// File: tb/sim_link_srv_req.sv
module sim_link_srv_req;
  localparam int N = 4;
  localparam int W = 2 * N;

  typedef struct packed {
    logic [3:0] ck, ak, en, rxm, txm;
    logic [7:0] st;
    logic       irq;
  } vec_t;

  // status bit 2p = rx (clock pin), 2p+1 = tx (ack pin)
  localparam vec_t VEC [6] = '{
    '{4'b0001, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 8'h01, 1'b1},
    '{4'b0000, 4'b0010, 4'b0000, 4'b1111, 4'b1111, 8'h08, 1'b1},
    '{4'b1000, 4'b0100, 4'b0000, 4'b0000, 4'b1111, 8'h60, 1'b1},
    '{4'b0100, 4'b0000, 4'b0000, 4'b1011, 4'b0000, 8'h10, 1'b0},
    '{4'b1111, 4'b1111, 4'b0101, 4'b1111, 4'b1111, 8'hCC, 1'b1},
    '{4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b1111, 8'h00, 1'b0}
  };

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] lnk_clk_i = '0, lnk_ack_i = '0, port_en_i = '0;
  logic [N-1:0] rx_mask_i = '1, tx_mask_i = '1;
  logic         rd_en_i = 1'b0, rd_view_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         irq_o;
  int           checks = 0, errors = 0;
  logic [W-1:0] rd_val;

  always #2.5 clk_i = ~clk_i;

  link_srv_req #(.N_PORTS(N)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_read(input logic view);
    rd_en_i = 1'b1; rd_view_i = view;
    #0.5 rd_val = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0; rd_view_i = 1'b0;
  endtask

  task automatic clean();
    lnk_clk_i = '0; lnk_ack_i = '0; port_en_i = '0;
    rx_mask_i = '1; tx_mask_i = '1;
    edges(3);
    do_read(1'b0);
    edges(2);
  endtask

  initial begin
    edges(2);
    chk("R1 status after reset", rd_data_o, 0);
    chk("R1 irq after reset", irq_o, 0);
    rst_ni = 1'b1;
    edges(2);
    chk("R1 status idle", rd_data_o, 0);

    // latency
    lnk_clk_i[0] = 1'b1;
    edges(2);
    chk("R4 not yet at edge 2", rd_data_o, 0);
    edges(1);
    chk("R4 set at edge 3", rd_data_o, 8'h01);
    chk("R9 irq one edge later", irq_o, 0);
    edges(1);
    chk("R9 irq rises", irq_o, 1);

    // sticky after pin falls
    lnk_clk_i[0] = 1'b0;
    edges(4);
    chk("R5 sticky", rd_data_o, 8'h01);

    do_read(1'b1);
    chk("R7 shadow data", rd_val, 8'h01);
    chk("R7 shadow no clear", rd_data_o, 8'h01);

    do_read(1'b0);
    chk("R6 main data", rd_val, 8'h01);
    chk("R6 main clears", rd_data_o, 0);
    chk("R9 irq still high", irq_o, 1);
    edges(1);
    chk("R9 irq falls", irq_o, 0);

    // read while condition present
    lnk_ack_i[1] = 1'b1;
    edges(4);
    chk("R2 ack -> tx bit", rd_data_o, 8'h08);
    do_read(1'b0);
    chk("R6 live bit kept", rd_data_o, 8'h08);
    lnk_ack_i[1] = 1'b0;
    edges(3);
    do_read(1'b0);
    chk("R6 cleared once gone", rd_data_o, 0);

    // enable forcing
    lnk_clk_i[2] = 1'b1;
    edges(4);
    chk("R2 clock -> rx bit", rd_data_o, 8'h10);
    port_en_i[2] = 1'b1;
    edges(1);
    chk("R3 enable clears", rd_data_o, 0);
    edges(4);
    chk("R3 held while enabled", rd_data_o, 0);
    port_en_i[2] = 1'b0;
    edges(1);
    chk("R3 sets once disabled", rd_data_o, 8'h10);

    // masks
    rx_mask_i[2] = 1'b0;
    edges(2);
    chk("R8 rx mask blocks", irq_o, 0);
    tx_mask_i[2] = 1'b0; rx_mask_i[2] = 1'b1;
    edges(1);
    chk("R8 rx mask passes", irq_o, 1);
    rx_mask_i[2] = 1'b0; tx_mask_i = '1;
    edges(2);
    chk("R8 tx mask ignores rx bit", irq_o, 0);
    clean();
    chk("R6 clean", rd_data_o, 0);

    for (int i = 0; i < 6; i++) begin
      lnk_clk_i = VEC[i].ck; lnk_ack_i = VEC[i].ak; port_en_i = VEC[i].en;
      rx_mask_i = VEC[i].rxm; tx_mask_i = VEC[i].txm;
      edges(5);
      chk($sformatf("R2/R3 vector %0d status", i), rd_data_o, VEC[i].st);
      chk($sformatf("R8/R9 vector %0d irq", i), irq_o, VEC[i].irq);
      clean();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule